// File: doc/BRIEF.md
# Phase-Selectable Decimating FIR Stage

This block is a late stage of a decimation chain. It low-pass filters a stream of signed samples and keeps one output for every `DECIM` accepted inputs. One instance built with `DECIM = 4` feeds a second instance built with `DECIM = 2`. The stage holds two coefficient sets in a ROM. One set is symmetric and gives a linear phase response. The other set is asymmetric and gives a minimum phase response, with most of its weight on the newest samples. A single control input picks between the two sets while the stage is running.

The stage computes nothing on the inputs that are thrown away by decimation. When the last input of a group arrives, one shared multiply-accumulate unit walks every tap of the selected set, one tap per clock. It then rounds the sum, saturates it, and presents it on a registered output. The sample rate must leave at least `NTAPS + 2` clocks between the last input of one group and the first input of the next. An input that arrives while a sum is still in progress is dropped and reported.

Coefficients use 27 fractional bits, so a value of 2^27 means unity gain. The samples are stored in a block-RAM-style circular buffer. When the coefficient set changes, the stored history is discarded, so no output mixes taps from the two sets.

Top module: `fir_decim_phase`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid`, `busy` and `overrun` are 0.
- R2: An input is accepted when `in_valid` is 1 and `busy` is 0. Accepted inputs form groups of `DECIM`. Only the last input of each group produces an output, so `out_valid` pulses exactly once per group.
- R3: `busy` rises on the clock edge that accepts the last input of a group. `out_valid` is a one-cycle pulse that rises exactly `NTAPS + 2` clock edges after that edge. `busy` falls on the same edge that raises `out_valid`.
- R4: When `phase_sel` is 0, the linear set is active. Its tap k (k = 0 is the newest sample) is `floor(2^27 / W) * w(k)`. Here `w(k) = min(k, NTAPS-1-k) + 1`, and W is the sum of w over all taps. This set is symmetric.
- R5: When `phase_sel` is 1, the minimum set is active. Its tap k is `2^(26-k)`, which is 2^26 for the newest sample. This set is asymmetric.
- R6: Before rounding, the result is the sum over k from 0 to `NTAPS-1` of `c(k) * x(n-k)`. Here x(n) is the last accepted input of the group, and any tap older than the retained history contributes 0.
- R7: The sum is rounded to nearest by computing `floor((acc + 2^26) / 2^27)`, so an exact half rounds toward positive infinity.
- R8: A rounded value above `2^(OUT_W-1) - 1` is output as that value, and a value below `-2^(OUT_W-1)` is output as that value.
- R9: A new `phase_sel` value takes effect only on the first accepted input of a group. A change made part way through a group does not alter that group's output.
- R10: When the set changes, all earlier samples are discarded. The first output under the new set uses only inputs accepted from the switching input onward.
- R11: An `in_valid` pulse seen while `busy` is 1 is dropped. It is not stored and does not advance the group count. `overrun` pulses for one cycle, on the edge after that input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_sel | input | 1 | Coefficient set request: 0 = linear, 1 = minimum |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a decimated result |
| out_data | output | OUT_W | Signed, rounded and saturated result |
| busy | output | 1 | High while a sum is in progress; inputs are refused |
| overrun | output | 1 | One-cycle pulse after an input was refused |

## Verification
The bench feeds impulse and step inputs under both coefficient sets. It compares every output cycle against a behavioural integer model, so a wrong tap order, a missing tap or an off-by-one in the buffer address shows up as a wrong value. It flips `phase_sel` part way through a group: a design that switches at once would change that group's output. After a switch it checks that old samples are gone: a design that keeps its history would leak earlier samples into the first new output. Single-unit impulses hit the exact half case, where truncating or rounding half away from zero gives the wrong answer. Full-scale steps into a narrowed output check that the result clamps rather than wraps. An input driven during `busy` must leave the later outputs unchanged, and a design that stored that input would shift every later group.

// File: rtl/fir_dp_pkg.sv
package fir_dp_pkg;

  // Fractional bits of every coefficient: 2**COEF_FRAC is unity gain.
  localparam int COEF_FRAC = 27;

  // Triangular weight of tap k in an n-tap symmetric set.
  function automatic int tri_weight(input int k, input int n);
    int lo;
    int hi;
    lo = k;
    hi = n - 1 - k;
    return ((lo < hi) ? lo : hi) + 1;
  endfunction

  // Linear phase set: scaled triangle, symmetric about the centre.
  function automatic longint lin_tap(input int k, input int n);
    longint total;
    longint step;
    total = 0;
    for (int j = 0; j < n; j++) total += longint'(tri_weight(j, n));
    step = (longint'(1) <<< COEF_FRAC) / total;
    return step * longint'(tri_weight(k, n));
  endfunction

  // Minimum phase set: halving weights, heaviest on the newest sample.
  function automatic longint min_tap(input int k);
    if (k > COEF_FRAC - 1) return 0;
    return longint'(1) <<< (COEF_FRAC - 1 - k);
  endfunction

endpackage

// File: rtl/fir_dp_coef_rom.sv
module fir_dp_coef_rom #(
  parameter int NTAPS  = 16,
  parameter int COEF_W = 28,
  parameter int TAP_AW = $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic                     phase,
  input  logic [TAP_AW-1:0]        tap,
  output logic signed [COEF_W-1:0] coef
);
  import fir_dp_pkg::*;

  localparam int DEPTH = 2 * NTAPS;
  localparam int ROM_AW = TAP_AW + 1;

  logic signed [COEF_W-1:0] rom [DEPTH];
  logic [ROM_AW-1:0]        addr;

  // Lower half holds the linear set, upper half the minimum set.
  initial begin
    for (int i = 0; i < NTAPS; i++) begin
      rom[i]         = COEF_W'(lin_tap(i, NTAPS));
      rom[NTAPS + i] = COEF_W'(min_tap(i));
    end
  end

  assign addr = phase ? (ROM_AW'(NTAPS) + ROM_AW'(tap)) : ROM_AW'(tap);

  always_ff @(posedge clk) begin
    if (rd_en) coef <= rom[addr];
  end

endmodule

// File: rtl/fir_dp_delay_line.sv
module fir_dp_delay_line #(
  parameter int NTAPS  = 16,
  parameter int DATA_W = 24,
  parameter int AW     = $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_clear,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_tap,
  output logic signed [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL = (AW + 1)'(NTAPS);

  logic signed [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]            head;
  logic [AW-1:0]            wr_addr;
  logic [AW-1:0]            rd_addr;
  logic [AW:0]              fill;
  logic signed [DATA_W-1:0] mem_q;
  logic                     live_q;

  assign wr_addr = head + AW'(1);
  assign rd_addr = head - rd_tap;

  // Storage: no reset, single write and single registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) mem_q <= mem[rd_addr];
  end

  // Pointer and occupancy. A clearing write leaves only the new sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      head   <= '0;
      fill   <= '0;
      live_q <= 1'b0;
    end else begin
      if (wr_en) begin
        head <= wr_addr;
        if (wr_clear)          fill <= (AW + 1)'(1);
        else if (fill != FULL) fill <= fill + (AW + 1)'(1);
      end
      if (rd_en) live_q <= ((AW + 1)'(rd_tap) < fill);
    end
  end

  assign rd_data = live_q ? mem_q : '0;

endmodule

// File: rtl/fir_dp_mac.sv
module fir_dp_mac #(
  parameter int NTAPS  = 16,
  parameter int IN_W   = 24,
  parameter int COEF_W = 28,
  parameter int OUT_W  = 24,
  parameter int TAP_AW = $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     rd_en,
  output logic [TAP_AW-1:0]        tap,
  input  logic signed [IN_W-1:0]   sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic                     busy,
  output logic                     res_valid,
  output logic signed [OUT_W-1:0]  res_data
);
  import fir_dp_pkg::*;

  localparam int PROD_W = IN_W + COEF_W;
  localparam int ACC_W  = PROD_W + TAP_AW + 1;
  localparam logic [TAP_AW-1:0] LAST = TAP_AW'(NTAPS - 1);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(longint'(1) <<< (COEF_FRAC - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((longint'(1) <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic                     run;
  logic [TAP_AW-1:0]        tap_q;
  logic                     rd_vld;
  logic                     rd_last;
  logic                     fin;
  logic signed [ACC_W-1:0]  acc;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  rnd;
  logic signed [ACC_W-1:0]  quot;
  logic signed [OUT_W-1:0]  sat;

  assign rd_en = run;
  assign tap   = tap_q;
  assign prod  = sample * coef;

  // Round half up, then clamp to the output range.
  always_comb begin
    rnd  = acc + HALF;
    quot = rnd >>> COEF_FRAC;
    if (quot > MAXV)      sat = MAXV[OUT_W-1:0];
    else if (quot < MINV) sat = MINV[OUT_W-1:0];
    else                  sat = quot[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      tap_q     <= '0;
      rd_vld    <= 1'b0;
      rd_last   <= 1'b0;
      fin       <= 1'b0;
      acc       <= '0;
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      fin       <= 1'b0;
      rd_vld    <= run;
      rd_last   <= run && (tap_q == LAST);
      if (start) begin
        run   <= 1'b1;
        tap_q <= '0;
        busy  <= 1'b1;
        acc   <= '0;
      end else if (run) begin
        tap_q <= tap_q + TAP_AW'(1);
        if (tap_q == LAST) run <= 1'b0;
      end
      if (rd_vld) acc <= acc + ACC_W'(prod);
      if (rd_vld && rd_last) fin <= 1'b1;
      if (fin) begin
        res_valid <= 1'b1;
        res_data  <= sat;
        busy      <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fir_decim_phase.sv
module fir_decim_phase #(
  parameter int DECIM  = 4,
  parameter int NTAPS  = 16,
  parameter int IN_W   = 24,
  parameter int OUT_W  = 24,
  parameter int COEF_W = 28
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    phase_sel,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data,
  output logic                    busy,
  output logic                    overrun
);
  localparam int TAP_AW = $clog2(NTAPS);
  localparam int CNT_W  = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECIM - 1);

  logic [CNT_W-1:0]         grp_cnt;
  logic                     phase_q;
  logic                     accept;
  logic                     grp_start;
  logic                     phase_switch;
  logic                     last_in;
  logic                     mac_rd;
  logic [TAP_AW-1:0]        mac_tap;
  logic signed [IN_W-1:0]   line_q;
  logic signed [COEF_W-1:0] coef_q;

  assign accept       = in_valid && !busy;
  assign grp_start    = accept && (grp_cnt == '0);
  assign phase_switch = grp_start && (phase_sel != phase_q);
  assign last_in      = accept && (grp_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_cnt <= '0;
      phase_q <= 1'b0;
      overrun <= 1'b0;
    end else begin
      overrun <= in_valid && busy;
      if (accept) grp_cnt <= last_in ? '0 : grp_cnt + CNT_W'(1);
      if (phase_switch) phase_q <= phase_sel;
    end
  end

  fir_dp_delay_line #(
    .NTAPS (NTAPS),
    .DATA_W(IN_W),
    .AW    (TAP_AW)
  ) u_line (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (accept),
    .wr_clear(phase_switch),
    .wr_data (in_data),
    .rd_en   (mac_rd),
    .rd_tap  (mac_tap),
    .rd_data (line_q)
  );

  fir_dp_coef_rom #(
    .NTAPS (NTAPS),
    .COEF_W(COEF_W),
    .TAP_AW(TAP_AW)
  ) u_rom (
    .clk  (clk),
    .rd_en(mac_rd),
    .phase(phase_q),
    .tap  (mac_tap),
    .coef (coef_q)
  );

  fir_dp_mac #(
    .NTAPS (NTAPS),
    .IN_W  (IN_W),
    .COEF_W(COEF_W),
    .OUT_W (OUT_W),
    .TAP_AW(TAP_AW)
  ) u_mac (
    .clk      (clk),
    .rst      (rst),
    .start    (last_in),
    .rd_en    (mac_rd),
    .tap      (mac_tap),
    .sample   (line_q),
    .coef     (coef_q),
    .busy     (busy),
    .res_valid(out_valid),
    .res_data (out_data)
  );

endmodule

// File: rtl/fir_decim_phase_chk.sv
module fir_decim_phase_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic busy,
  input logic out_valid,
  input logic overrun,
  input logic phase_q,
  input logic grp_start
);

  // R3: the result strobe lasts a single cycle.
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R3: busy ends only together with a result.
  p_busy_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_valid);

  // R3: a result is only produced at the end of a busy period.
  p_out_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));

  // R11: an overrun pulse always has a refused input behind it.
  p_overrun_cause_r11: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(in_valid && busy));

  // R11: every refused input is reported.
  p_overrun_seen_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && busy) |=> overrun);

  // R9: the active set only moves on the first input of a group.
  p_phase_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) |-> $past(grp_start));

  // R9: the active set cannot change while a sum is running.
  p_phase_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(phase_q));

endmodule

bind fir_decim_phase fir_decim_phase_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .busy     (busy),
  .out_valid(out_valid),
  .overrun  (overrun),
  .phase_q  (phase_q),
  .grp_start(grp_start)
);

// File: tb/tb_fir_decim_phase.sv
module tb_fir_decim_phase;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int N  = 16;
  localparam int IW = 24;
  localparam int OW = 20;
  localparam int CW = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_sel = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IW-1:0] in_data = '0;
  logic out_valid, busy, overrun;
  logic signed [OW-1:0] out_data;

  int checks = 0;
  int fails = 0;
  string cur_req = "R6";
  bit run_checks = 0;

  // Behavioural model state.
  longint hist[$];
  int     m_phase = 0;
  int     m_cnt = 0;
  int     m_cd = 0;
  bit     m_busy = 0;
  bit     was_busy = 0;
  bit     e_valid = 0;
  bit     e_ovr = 0;
  longint e_data = 0;
  longint pend = 0;

  fir_decim_phase #(.DECIM(D), .NTAPS(N), .IN_W(IW), .OUT_W(OW), .COEF_W(CW)) dut (
    .clk(clk), .rst(rst), .phase_sel(phase_sel), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .busy(busy), .overrun(overrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Coefficients from R4 and R5.
  function automatic longint ref_coef(input int ph, input int k);
    longint wsum;
    longint wk;
    if (ph == 1) return (k <= 26) ? (longint'(1) <<< (26 - k)) : 0;
    wsum = 0;
    for (int j = 0; j < N; j++) wsum += (j < N - 1 - j) ? j + 1 : N - j;
    wk = (k < N - 1 - k) ? k + 1 : N - k;
    return ((longint'(1) <<< 27) / wsum) * wk;
  endfunction

  // R6, R7, R8 on the model history.
  function automatic longint ref_out();
    longint acc;
    longint r;
    longint hi;
    acc = 0;
    for (int k = 0; k < hist.size(); k++) acc += hist[k] * ref_coef(m_phase, k);
    r = (acc + (longint'(1) <<< 26)) >>> 27;
    hi = (longint'(1) <<< (OW - 1)) - 1;
    if (r > hi) r = hi;
    if (r < -hi - 1) r = -hi - 1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      m_phase = 0; m_cnt = 0; m_cd = 0; m_busy = 0;
      e_valid = 0; e_ovr = 0; e_data = 0;
    end else begin
      was_busy = m_busy;
      e_valid = 0;
      e_ovr = in_valid && was_busy;
      if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin
          e_valid = 1; e_data = pend; m_busy = 0;
        end
      end
      if (in_valid && !was_busy) begin
        if (m_cnt == 0 && int'(phase_sel) != m_phase) begin
          m_phase = int'(phase_sel);
          hist.delete();
        end
        hist.push_front(longint'(in_data));
        if (hist.size() > N) void'(hist.pop_back());
        m_cnt++;
        if (m_cnt == D) begin
          m_cnt = 0; pend = ref_out(); m_cd = N + 2; m_busy = 1;
        end
      end
    end
  end

  task automatic check_val(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && run_checks) begin
      check_val("R2", "out_valid", longint'(out_valid), longint'(e_valid));
      check_val("R3", "busy", longint'(busy), longint'(m_busy));
      check_val("R11", "overrun", longint'(overrun), longint'(e_ovr));
      if (e_valid && out_valid) check_val(cur_req, "out_data", longint'(out_data), e_data);
    end
  end

  task automatic put(input longint x);
    in_valid = 1'b1;
    in_data = IW'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (N + 3) @(negedge clk);
  endtask

  task automatic group(input longint a, input longint b, input longint c, input longint d);
    put(a); put(b); put(c); put(d);
    settle();
  endtask

  task automatic flat(input longint x, input int ngroups);
    for (int g = 0; g < ngroups; g++) group(x, x, x, x);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R3 watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset.
    check_val("R1", "reset out_valid", longint'(out_valid), 0);
    check_val("R1", "reset busy", longint'(busy), 0);
    check_val("R1", "reset overrun", longint'(overrun), 0);
    rst = 1'b0;
    @(negedge clk);
    check_val("R1", "post-reset out_valid", longint'(out_valid), 0);
    check_val("R1", "post-reset busy", longint'(busy), 0);
    run_checks = 1;

    // R4: linear set impulse, then R6 step.
    cur_req = "R4";
    group(1000000, 0, 0, 0);
    flat(0, 5);
    cur_req = "R6";
    flat(3000000, 6);
    group(-2500000, 1234567, -7, 400000);

    // R9: request minimum set part way through a group.
    cur_req = "R9";
    put(500000); put(-500000);
    phase_sel = 1'b1;
    put(250000); put(0);
    settle();

    // R10: switch happens here and history is dropped.
    cur_req = "R10";
    group(2000000, 0, 0, 0);
    // R5: minimum set impulse tail and step.
    cur_req = "R5";
    flat(0, 5);
    flat(-1500000, 6);

    // R7: exact half cases.
    cur_req = "R7";
    flat(0, 5);
    group(0, 0, 0, 1);
    flat(0, 5);
    group(0, 0, 0, -1);
    flat(0, 5);
    group(0, 0, 0, 3);

    // R8: saturation both ways.
    cur_req = "R8";
    flat(8388607, 6);
    flat(-8388608, 6);

    // R11: refused input must not shift later groups.
    cur_req = "R11";
    flat(0, 5);
    put(700000); put(0); put(0); put(0);
    put(-8000000);
    settle();
    group(0, 0, 0, 0);
    group(100000, 0, 0, 0);

    // R10: back to the linear set, old samples discarded.
    cur_req = "R10";
    phase_sel = 1'b0;
    group(-900000, 0, 0, 0);
    cur_req = "R4";
    flat(0, 5);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule